// File: doc/BRIEF.md
# I2C-over-AUX EDID Responder

This block answers I2C requests that a host tunnels through an AUX-channel register window, so that the host can read a display's EDID bytes. The window has one control register and five data registers. The host first writes a request header into data register 1. It then writes the control register with the send-busy bit set. In the same clock edge the responder decodes the header, updates its target-selection state and the shared EDID read pointer, and replaces the control register with a completed status word. Where the request calls for it, the responder also writes a reply word back into data register 1.

Three-byte messages carry only an address phase: a start, a restart or a stop. Four-byte read messages fetch one EDID byte each. I2C write requests are acknowledged and discarded. The EDID store lives outside the block. The responder presents the pointer on `edid_idx` and takes the addressed byte back on `edid_byte` in the same cycle.

Top module: `aux_edid_responder`

## Requirements
- R1: After reset every register in the window reads 0, the selection state is cleared and `edid_idx` is 0.
- R2: A write to low address byte 0x14, 0x18, 0x1C, 0x20 or 0x24 (data registers 1 to 5) stores the value, which reads back at the same address. Writes to any address outside the window and the control register are dropped, and such addresses read 0.
- R3: A write to the control register (0x10) with bit 31 (send-busy) clear changes no register and no state.
- R4: A control write with bit 31 set replaces the control register with bit 30 (done) plus a reply size in bits 24:20. The size is 2 when the opcode (header bits 31:28) has bit 0 set (read), so the register reads 0x40200000. It is 1 for a write, so the register reads 0x40100000.
- R5: A 3-byte message (control bits 24:20 = 3) with opcode bit 2 (middle-of-transaction) clear is a stop. It deselects the target, clears EDID availability and returns the pointer to 0.
- R6: A 3-byte message with opcode bit 2 set and header bits 23:8 equal to 0x0050 selects the EDID target. It marks EDID available only while `monitor_present` and `monitor_is_dp` are both high. Any other non-zero address leaves the state unchanged.
- R7: A 3-byte message with opcode bit 2 set and address 0 clears the selection state and the pointer, as a stop does.
- R8: A 4-byte read with the target selected and available returns the EDID byte at the pointer in reply bits 23:16, and the pointer advances by one.
- R9: The pointer never exceeds EDID_BYTES. A 4-byte read at the end of the store returns 0x00 in bits 23:16 and leaves the pointer where it is.
- R10: A read request whose length is neither 3 nor 4 leaves data register 1 untouched. The control register is still completed.
- R11: A 4-byte read with no target selected, or with EDID unavailable, returns 0xFF in bits 23:16. A write request's reply has bits 23:0 at zero.
- R12: Every reply written to data register 1 carries the ACK code 0x00 in bits 31:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Low address byte of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Low address byte of the read |
| rd_data | output | 32 | Read data for rd_addr (combinational) |
| monitor_present | input | 1 | A display is attached to this port |
| monitor_is_dp | input | 1 | The attached display uses the AUX-channel protocol |
| edid_idx | output | IDX_W | EDID store byte index (low bits of the read pointer) |
| edid_byte | input | 8 | EDID byte at edid_idx |

## Verification
Every fault in the selection or pointer state shows up at the ports within one request. A stale selection turns an expected 0xFF into EDID data, or the reverse, in the very next 4-byte read reply. A pointer that slips or fails to advance appears at once on `edid_idx`, and it also returns a byte from the wrong position in the next reply. A wrong opcode or length decode shows up in the completed control word or in data register 1 one cycle after the control write. The bench therefore reads the window and `edid_idx` after every request, with the expected bytes computed from a function of the index.

// File: rtl/aux_edid_pkg.sv
package aux_edid_pkg;
    localparam logic [7:0] CTL_OFS     = 8'h10;
    localparam logic [7:0] DATA_OFS    = 8'h14;
    localparam int         DATA_STRIDE = 4;
    localparam int         NUM_DATA    = 5;
    localparam int         DIDX_W      = $clog2(NUM_DATA);

    localparam int BUSY_BIT = 31;
    localparam int DONE_BIT = 30;
    localparam int SIZE_LO  = 20;
    localparam int SIZE_W   = 5;

    localparam logic [7:0] ACK_CODE = 8'h00;

    typedef struct packed {
        logic        is_read;
        logic        mot;
        logic [15:0] i2c_addr;
    } aux_hdr_t;
endpackage

// File: rtl/aux_reg_sel.sv
module aux_reg_sel
    import aux_edid_pkg::*;
(
    input  logic [7:0]        addr,
    output logic              is_ctl,
    output logic              is_data,
    output logic [DIDX_W-1:0] data_idx
);
    always_comb begin
        is_ctl   = (addr == CTL_OFS);
        is_data  = 1'b0;
        data_idx = '0;
        for (int i = 0; i < NUM_DATA; i++) begin
            if (addr == DATA_OFS + 8'(i * DATA_STRIDE)) begin
                is_data  = 1'b1;
                data_idx = DIDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/aux_hdr_decode.sv
module aux_hdr_decode
    import aux_edid_pkg::*;
(
    input  logic [31:0] hdr_word,
    output aux_hdr_t    hdr
);
    logic [3:0] opcode;

    always_comb begin
        opcode       = hdr_word[31:28];
        hdr.is_read  = opcode[0];
        hdr.mot      = opcode[2];
        hdr.i2c_addr = hdr_word[23:8];
    end
endmodule

// File: rtl/aux_edid_fetch.sv
module aux_edid_fetch #(
    parameter int EDID_BYTES = 128,
    parameter int PTR_W      = $clog2(EDID_BYTES + 1)
) (
    input  logic             selected,
    input  logic             avail,
    input  logic [PTR_W-1:0] ptr,
    input  logic [7:0]       edid_byte,
    output logic [7:0]       reply_byte,
    output logic             advance
);
    logic in_range;

    always_comb begin
        in_range = (ptr < PTR_W'(EDID_BYTES));
        advance  = selected && avail && in_range;
        if (!(selected && avail))
            reply_byte = 8'hFF;
        else if (in_range)
            reply_byte = edid_byte;
        else
            reply_byte = 8'h00;
    end
endmodule

// File: rtl/aux_edid_responder.sv
module aux_edid_responder
    import aux_edid_pkg::*;
#(
    parameter int          EDID_BYTES    = 128,
    parameter logic [15:0] EDID_I2C_ADDR = 16'h0050,
    parameter int          IDX_W         = $clog2(EDID_BYTES),
    parameter int          PTR_W         = $clog2(EDID_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [7:0]       rd_addr,
    output logic [31:0]      rd_data,
    input  logic             monitor_present,
    input  logic             monitor_is_dp,
    output logic [IDX_W-1:0] edid_idx,
    input  logic [7:0]       edid_byte
);
    typedef struct packed {
        logic [31:0]                ctrl;
        logic [NUM_DATA-1:0][31:0]  data;
        logic                       selected;
        logic                       avail;
        logic [PTR_W-1:0]           ptr;
    } state_t;

    state_t st_d, st_q;

    logic              wr_is_ctl, wr_is_data;
    logic [DIDX_W-1:0] wr_idx;
    logic              rd_is_ctl, rd_is_data;
    logic [DIDX_W-1:0] rd_idx;
    aux_hdr_t          hdr;
    logic [7:0]        fetch_byte;
    logic              fetch_adv;

    aux_reg_sel u_wr_sel (.addr(wr_addr), .is_ctl(wr_is_ctl), .is_data(wr_is_data), .data_idx(wr_idx));
    aux_reg_sel u_rd_sel (.addr(rd_addr), .is_ctl(rd_is_ctl), .is_data(rd_is_data), .data_idx(rd_idx));

    aux_hdr_decode u_hdr (.hdr_word(st_q.data[0]), .hdr(hdr));

    aux_edid_fetch #(.EDID_BYTES(EDID_BYTES), .PTR_W(PTR_W)) u_fetch (
        .selected  (st_q.selected),
        .avail     (st_q.avail),
        .ptr       (st_q.ptr),
        .edid_byte (edid_byte),
        .reply_byte(fetch_byte),
        .advance   (fetch_adv)
    );

    logic [SIZE_W-1:0] msg_len;
    logic              busy_wr;
    logic              len3, len4;
    logic              put_reply;
    logic [31:0]       reply;

    assign msg_len = wr_data[SIZE_LO +: SIZE_W];
    assign busy_wr = wr_en && wr_is_ctl && wr_data[BUSY_BIT];
    assign len3    = (msg_len == SIZE_W'(3));
    assign len4    = (msg_len == SIZE_W'(4));

    always_comb begin
        st_d      = st_q;
        put_reply = 1'b0;
        reply     = {ACK_CODE, 24'h0};
        if (busy_wr) begin
            st_d.ctrl                     = '0;
            st_d.ctrl[DONE_BIT]           = 1'b1;
            st_d.ctrl[SIZE_LO +: SIZE_W]  = hdr.is_read ? SIZE_W'(2) : SIZE_W'(1);
            put_reply                     = 1'b1;
            if (len3) begin
                if (!hdr.mot || hdr.i2c_addr == 16'h0000) begin
                    st_d.selected = 1'b0;
                    st_d.avail    = 1'b0;
                    st_d.ptr      = '0;
                end else if (hdr.i2c_addr == EDID_I2C_ADDR) begin
                    st_d.selected = 1'b1;
                    if (monitor_present && monitor_is_dp)
                        st_d.avail = 1'b1;
                end
            end else if (!hdr.is_read) begin
                put_reply = 1'b1;
            end else if (!len4) begin
                put_reply = 1'b0;
            end else begin
                reply[23:16] = fetch_byte;
                if (fetch_adv)
                    st_d.ptr = st_q.ptr + PTR_W'(1);
            end
            if (put_reply)
                st_d.data[0] = reply;
        end else if (wr_en && wr_is_data) begin
            st_d.data[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        if (rd_is_ctl)
            rd_data = st_q.ctrl;
        else if (rd_is_data)
            rd_data = st_q.data[rd_idx];
        else
            rd_data = '0;
    end

    assign edid_idx = st_q.ptr[IDX_W-1:0];

    // Assertions placed beside the state they guard
    assert_idle_ctl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_is_ctl && !wr_data[BUSY_BIT]) |=> ($stable(st_q.ctrl) && $stable(st_q.data) && $stable(st_q.ptr)));

    assert_done_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_wr |=> (st_q.ctrl[DONE_BIT] && !st_q.ctrl[BUSY_BIT]));

    assert_stop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_wr && len3 && !hdr.mot) |=> (!st_q.selected && !st_q.avail && st_q.ptr == '0));

    assert_avail_needs_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.avail |-> st_q.selected);

    assert_ptr_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ptr <= PTR_W'(EDID_BYTES));

    assert_badlen_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_wr && hdr.is_read && !len3 && !len4) |=> $stable(st_q.data[0]));

    assert_unsel_ff_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_wr && hdr.is_read && len4 && !st_q.selected) |=> (st_q.data[0][23:16] == 8'hFF));

    assert_ack_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_wr && !(hdr.is_read && !len3 && !len4)) |=> (st_q.data[0][31:24] == ACK_CODE));
endmodule

// File: tb/aux_edid_responder_tb_top.sv
module aux_edid_responder_tb_top;
    localparam int EDID_BYTES = 128;
    localparam int IDX_W      = $clog2(EDID_BYTES);
    localparam logic [7:0] IDX_TAG = 8'hFF;

    localparam logic [31:0] CTL3 = 32'h8030_0000;
    localparam logic [31:0] CTL4 = 32'h8040_0000;
    localparam logic [31:0] CTL5 = 32'h8050_0000;
    localparam logic [31:0] HDR_SEL   = 32'h5000_5000;
    localparam logic [31:0] HDR_RD    = 32'h1000_0000;
    localparam logic [31:0] HDR_WR    = 32'h0000_0000;
    localparam logic [31:0] HDR_ADDR0 = 32'h5000_0000;
    localparam logic [31:0] HDR_STOP  = 32'h1000_5000;
    localparam logic [31:0] HDR_OTHER = 32'h5000_3700;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [7:0]       wr_addr = '0;
    logic [31:0]      wr_data = '0;
    logic [7:0]       rd_addr = '0;
    logic [31:0]      rd_data;
    logic             monitor_present = 1'b0;
    logic             monitor_is_dp = 1'b0;
    logic [IDX_W-1:0] edid_idx;
    logic [7:0]       edid_byte;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] edid_val(input int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction

    function automatic logic [31:0] rd_reply(input int i);
        return {8'h00, edid_val(i), 16'h0000};
    endfunction

    assign edid_byte = edid_val(int'(edid_idx));

    aux_edid_responder #(.EDID_BYTES(EDID_BYTES)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .monitor_present(monitor_present),
        .monitor_is_dp(monitor_is_dp), .edid_idx(edid_idx), .edid_byte(edid_byte)
    );

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic aux_req(input logic [31:0] hdr, input logic [31:0] ctl);
        wr(8'h14, hdr);
        wr(8'h10, ctl);
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        if (a != IDX_TAG) rd_addr = a;
        it.addr = a; it.exp = e; it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
    endtask

    initial begin : monitor
        item_t it;
        logic [31:0] act;
        forever begin
            @(negedge clk);
            #1;
            if (sbq.size() > 0) begin
                it = sbq.pop_front();
                act = (it.addr == IDX_TAG) ? 32'(edid_idx) : rd_data;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        expect_reg(8'h10, 32'h0, "R1 ctrl");
        expect_reg(8'h14, 32'h0, "R1 data1");
        expect_reg(8'h24, 32'h0, "R1 data5");
        expect_reg(IDX_TAG, 32'h0, "R1 idx");
        // R2 data storage and out-of-window addresses
        wr(8'h14, 32'hDEAD_BEEF);
        wr(8'h24, 32'h1234_5678);
        wr(8'h30, 32'hFFFF_FFFF);
        expect_reg(8'h14, 32'hDEAD_BEEF, "R2 data1");
        expect_reg(8'h24, 32'h1234_5678, "R2 data5");
        expect_reg(8'h30, 32'h0, "R2 outside");
        // R3 control write without send-busy
        wr(8'h10, 32'h0030_0000);
        expect_reg(8'h10, 32'h0, "R3 ctrl");
        expect_reg(8'h14, 32'hDEAD_BEEF, "R3 data1");
        // R6 select with DP monitor
        monitor_present = 1'b1; monitor_is_dp = 1'b1;
        aux_req(HDR_SEL, CTL3);
        expect_reg(8'h10, 32'h4020_0000, "R4 read size");
        expect_reg(8'h14, 32'h0, "R12 start reply");
        // R8 reads
        aux_req(HDR_RD, CTL4);
        expect_reg(8'h14, rd_reply(0), "R8 byte0");
        expect_reg(IDX_TAG, 32'd1, "R8 idx1");
        aux_req(HDR_RD, CTL4);
        expect_reg(8'h14, rd_reply(1), "R8 byte1");
        // R11 write request
        aux_req(HDR_WR, CTL4);
        expect_reg(8'h10, 32'h4010_0000, "R4 write size");
        expect_reg(8'h14, 32'h0, "R11 write reply");
        expect_reg(IDX_TAG, 32'd2, "R11 idx kept");
        aux_req(HDR_RD, CTL4);
        expect_reg(8'h14, rd_reply(2), "R8 byte2");
        // R10 bad length
        aux_req(HDR_RD, CTL5);
        expect_reg(8'h14, HDR_RD, "R10 data1 kept");
        expect_reg(8'h10, 32'h4020_0000, "R10 ctrl done");
        expect_reg(IDX_TAG, 32'd3, "R10 idx kept");
        // R7 address 0 resets
        aux_req(HDR_ADDR0, CTL3);
        expect_reg(IDX_TAG, 32'd0, "R7 idx");
        aux_req(HDR_RD, CTL4);
        expect_reg(8'h14, 32'h00FF_0000, "R7 deselected");
        // R5 stop
        aux_req(HDR_SEL, CTL3);
        aux_req(HDR_RD, CTL4);
        expect_reg(8'h14, rd_reply(0), "R5 before stop");
        aux_req(HDR_STOP, CTL3);
        expect_reg(IDX_TAG, 32'd0, "R5 idx");
        aux_req(HDR_RD, CTL4);
        expect_reg(8'h14, 32'h00FF_0000, "R5 after stop");
        // R6 / R11 no DP monitor
        monitor_is_dp = 1'b0;
        aux_req(HDR_SEL, CTL3);
        aux_req(HDR_RD, CTL4);
        expect_reg(8'h14, 32'h00FF_0000, "R11 unavailable");
        expect_reg(IDX_TAG, 32'd0, "R6 no dp idx");
        // R6 other address leaves state
        monitor_is_dp = 1'b1;
        aux_req(HDR_STOP, CTL3);
        aux_req(HDR_SEL, CTL3);
        aux_req(HDR_RD, CTL4);
        expect_reg(8'h14, rd_reply(0), "R6 selected");
        aux_req(HDR_OTHER, CTL3);
        aux_req(HDR_RD, CTL4);
        expect_reg(8'h14, rd_reply(1), "R6 other addr");
        // R9 end of store
        for (int i = 2; i < EDID_BYTES; i++) aux_req(HDR_RD, CTL4);
        expect_reg(8'h14, rd_reply(EDID_BYTES - 1), "R9 last byte");
        aux_req(HDR_RD, CTL4);
        expect_reg(8'h14, 32'h0, "R9 past end");
        expect_reg(IDX_TAG, 32'd0, "R9 idx");
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule